// File: doc/BRIEF.md
# RTC Indexed Register Access Port

This block gives a host processor byte access to the register file of a real-time clock through four byte-wide I/O offsets. The register file is two 128-byte banks. The standard bank holds ten time, date and alarm bytes, four control registers and general user RAM. The extended bank is all general RAM. Each bank has its own pair of offsets. The host first writes a byte index to the index offset of a pair. It then reads or writes the data offset of that pair, which acts on the byte the latched index points at.

The extended pair can be switched off with `ext_en`. While it is off, offsets 2 and 3 act on the standard index and the standard bank, exactly as offsets 0 and 1 do. The time-keeping counters sit outside this block. They signal an update with `upd_busy` and write their results back through a private port that always has priority. During an update, host writes to the ten time bytes are dropped without any notice. Every other byte stays fully writable and readable.

Top module: `rtc_index_port`

## Requirements
- R1: Reset (active-low `rst_n`, synchronous) sets both index latches to 00h. Bank contents are not changed by reset.
- R2: A write to offset 0 loads the standard index. A write to offset 1 stores the byte at that index. A read of offset 1 puts the byte on `host_rdata` at the next rising clock edge, and `host_rdata` then holds that value until the next data read.
- R3: When `ext_en`=1, offset 2 loads the extended index and offset 3 accesses the extended bank. This has no effect on the standard index or the standard bank.
- R4: An index stays latched across any number of data accesses. Each data access uses the index most recently written to the index offset of the same pair.
- R5: An index is 7 bits wide. Bit 7 of a byte written to an index offset is discarded, so writing C5h selects index 45h.
- R6: When `ext_en`=0, offsets 2 and 3 behave as offsets 0 and 1. The extended index and the extended bank are left untouched.
- R7: When `upd_busy`=1, a host write to standard indices 00h–09h is dropped and the byte keeps its old value.
- R8: When `upd_busy`=1, host writes and reads of standard indices 0Ah–7Fh work normally.
- R9: When `tk_we`=1, `tk_wdata` is written to standard index `tk_idx`. If the host writes the same byte in the same cycle, the time-keeping value is the one kept.
- R10: Extended bank writes are never blocked by `upd_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | I/O offset: 0 std index, 1 std data, 2 ext index, 3 ext data |
| host_wr | input | 1 | Host write strobe (one cycle) |
| host_rd | input | 1 | Host read strobe (one cycle) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| ext_en | input | 1 | 1 enables the extended pair; 0 aliases offsets 2/3 to 0/1 |
| upd_busy | input | 1 | Time-keeping update in progress |
| tk_we | input | 1 | Time-keeping write strobe |
| tk_idx | input | 7 | Time-keeping write index (00h–09h) |
| tk_wdata | input | 8 | Time-keeping write byte |

## Verification
The bench fills both banks with distinct patterns and then places the same index in the two pairs. A design that mixed up the banks, or that let an offset-2 write leak into the wrong latch, therefore returns the other bank's byte. Aliasing is tested by writing through offsets 2 and 3 while the extended pair is off, then turning the pair back on. A wrong alias shows up either as a corrupted extended byte or as a lost extended index. Update blocking is probed at 05h and 09h, where writes must be dropped, and at 0Ah and 0Eh, where they must land. An off-by-one guard, or a guard applied to the wrong bank, fails one of these probes. A host write and a time-keeping write collide on the same byte, and if the priority is inverted the host's value is the one that survives.

// File: rtl/rtc_idx_pkg.sv
// Package: shared sizing for the RTC indexed access port.
// Assumes byte-wide banks addressed by a 7-bit index.
package rtc_idx_pkg;
    parameter int DATA_W    = 8;
    parameter int IDX_W     = 7;
    parameter int BANK_SIZE = 1 << IDX_W;
    parameter int TIME_BYTES = 10;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/rtc_port_decode.sv
// Module: rtc_port_decode
// Turns the 2-bit offset and strobes into per-bank index/data strobes.
// Assumes host_wr and host_rd are never both high. When ext_en is low,
// offsets 2/3 fold onto the standard pair.
module rtc_port_decode (
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       ext_en,
    output logic       std_idx_we,
    output logic       ext_idx_we,
    output logic       std_dat_we,
    output logic       ext_dat_we,
    output logic       std_dat_re,
    output logic       ext_dat_re
);
    logic to_ext;
    logic is_data;

    // Pick the bank and the index/data role from the offset.
    always_comb begin
        to_ext     = host_addr[1] & ext_en;
        is_data    = host_addr[0];
        std_idx_we = host_wr & ~is_data & ~to_ext;
        ext_idx_we = host_wr & ~is_data &  to_ext;
        std_dat_we = host_wr &  is_data & ~to_ext;
        ext_dat_we = host_wr &  is_data &  to_ext;
        std_dat_re = host_rd &  is_data & ~to_ext;
        ext_dat_re = host_rd &  is_data &  to_ext;
    end
endmodule

// File: rtl/rtc_index_reg.sv
// Module: rtc_index_reg
// One index latch. It keeps the low IDX_W bits of the written byte and
// drops the rest. Clears to zero on synchronous reset.
module rtc_index_reg
    import rtc_idx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  byte_t wdata,
    output idx_t  idx
);
    // Capture a new index on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  idx <= '0;
        else if (we) idx <= wdata[IDX_W-1:0];
    end
endmodule

// File: rtl/rtc_byte_bank.sv
// Module: rtc_byte_bank
// A 128-byte bank with one host write port, one optional time-keeping
// write port and a combinational read. When GUARD_BYTES > 0, host writes
// below that index are dropped while upd_busy is high. The time-keeping
// port is applied last, so it wins on a shared index. Contents are not reset.
module rtc_byte_bank
    import rtc_idx_pkg::*;
#(
    parameter int GUARD_BYTES = 0
) (
    input  logic  clk,
    input  logic  host_we,
    input  idx_t  host_idx,
    input  byte_t host_wdata,
    input  logic  upd_busy,
    input  logic  tk_we,
    input  idx_t  tk_idx,
    input  byte_t tk_wdata,
    input  idx_t  rd_idx,
    output byte_t rd_byte
);
    byte_t mem [BANK_SIZE];
    logic  host_ok;

    generate
        if (GUARD_BYTES > 0) begin : g_guard
            // Block host writes to the guarded bytes during an update.
            always_comb host_ok = host_we &
                ~(upd_busy & (host_idx < IDX_W'(GUARD_BYTES)));
        end else begin : g_open
            // No guard on this bank.
            always_comb host_ok = host_we;
        end
    endgenerate

    // Store host, then time-keeping writes (later assignment wins).
    always_ff @(posedge clk) begin
        if (host_ok) mem[host_idx] <= host_wdata;
        if (tk_we)   mem[tk_idx]   <= tk_wdata;
    end

    // Combinational read of the selected byte.
    always_comb rd_byte = mem[rd_idx];
endmodule

// File: rtl/rtc_index_port.sv
// Module: rtc_index_port
// Top of the RTC indexed access port: offset decode, two index latches,
// the standard bank (time bytes guarded) and the extended bank, plus a
// registered read-data register.
// Assumes one host strobe per cycle. The time-keeping port only targets
// the time bytes.
module rtc_index_port
    import rtc_idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ext_en,
    input  logic              upd_busy,
    input  logic              tk_we,
    input  logic [IDX_W-1:0]  tk_idx,
    input  logic [DATA_W-1:0] tk_wdata
);
    logic  std_idx_we, ext_idx_we, std_dat_we, ext_dat_we;
    logic  std_dat_re, ext_dat_re;
    idx_t  std_idx, ext_idx;
    byte_t std_byte, ext_byte;

    rtc_port_decode u_dec (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .ext_en    (ext_en),
        .std_idx_we(std_idx_we),
        .ext_idx_we(ext_idx_we),
        .std_dat_we(std_dat_we),
        .ext_dat_we(ext_dat_we),
        .std_dat_re(std_dat_re),
        .ext_dat_re(ext_dat_re)
    );

    rtc_index_reg u_std_idx (
        .clk(clk), .rst_n(rst_n), .we(std_idx_we), .wdata(host_wdata), .idx(std_idx)
    );

    rtc_index_reg u_ext_idx (
        .clk(clk), .rst_n(rst_n), .we(ext_idx_we), .wdata(host_wdata), .idx(ext_idx)
    );

    rtc_byte_bank #(.GUARD_BYTES(TIME_BYTES)) u_std_bank (
        .clk       (clk),
        .host_we   (std_dat_we),
        .host_idx  (std_idx),
        .host_wdata(host_wdata),
        .upd_busy  (upd_busy),
        .tk_we     (tk_we),
        .tk_idx    (tk_idx),
        .tk_wdata  (tk_wdata),
        .rd_idx    (std_idx),
        .rd_byte   (std_byte)
    );

    rtc_byte_bank #(.GUARD_BYTES(0)) u_ext_bank (
        .clk       (clk),
        .host_we   (ext_dat_we),
        .host_idx  (ext_idx),
        .host_wdata(host_wdata),
        .upd_busy  (upd_busy),
        .tk_we     (1'b0),
        .tk_idx    ('0),
        .tk_wdata  ('0),
        .rd_idx    (ext_idx),
        .rd_byte   (ext_byte)
    );

    // Register the byte of whichever bank a data read targets.
    always_ff @(posedge clk) begin
        if (!rst_n)          host_rdata <= '0;
        else if (std_dat_re) host_rdata <= std_byte;
        else if (ext_dat_re) host_rdata <= ext_byte;
    end
endmodule

// File: rtl/rtc_index_port_chk.sv
// Module: rtc_index_port_chk
// Protocol checks on the index latches of rtc_index_port, bound below.
module rtc_index_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_addr,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic       ext_en,
    input logic [6:0] std_idx,
    input logic [6:0] ext_idx
);
    // R1
    idx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (std_idx == 7'd0 && ext_idx == 7'd0));

    // R2
    std_idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd0) |=> (std_idx == $past(host_wdata[6:0])));

    // R3
    ext_idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2 && ext_en)
            |=> (ext_idx == $past(host_wdata[6:0]) && $stable(std_idx)));

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_addr[0]) |=> ($stable(std_idx) && $stable(ext_idx)));

    // R6
    alias_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2 && !ext_en)
            |=> (std_idx == $past(host_wdata[6:0]) && $stable(ext_idx)));
endmodule

bind rtc_index_port rtc_index_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_wdata(host_wdata),
    .ext_en    (ext_en),
    .std_idx   (std_idx),
    .ext_idx   (ext_idx)
);

// File: tb/rtc_index_port_tb.sv
// Directed bench for rtc_index_port. Each scenario task checks its own results.
module rtc_index_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ext_en = 1'b1, upd_busy = 1'b0, tk_we = 1'b0;
    logic [6:0] tk_idx = '0;
    logic [7:0] tk_wdata = '0;

    int n_chk = 0, n_bad = 0;
    logic [7:0] std_m [128];
    logic [7:0] ext_m [128];

    always #10 clk = ~clk;  // 50 MHz

    rtc_index_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ext_en(ext_en), .upd_busy(upd_busy), .tk_we(tk_we), .tk_idx(tk_idx),
        .tk_wdata(tk_wdata)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic fill_banks();
        for (int i = 0; i < 128; i++) begin
            std_m[i] = 8'(i) ^ 8'h5A;
            ext_m[i] = ~(8'(i) ^ 8'h21);
            wr(2'd0, 8'(i)); wr(2'd1, std_m[i]);
            wr(2'd2, 8'(i)); wr(2'd3, ext_m[i]);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        check("R1 rdata after reset", host_rdata, 8'h00);
        rd(2'd1, v); check("R1 std index is 00h", v, std_m[0]);
        rd(2'd3, v); check("R1 ext index is 00h", v, ext_m[0]);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        wr(2'd0, 8'h20); wr(2'd1, 8'h3C); std_m[8'h20] = 8'h3C;
        rd(2'd1, v); check("R2 std write/read 20h", v, 8'h3C);
        wr(2'd0, 8'h0B); rd(2'd1, v); check("R2 std read 0Bh", v, std_m[8'h0B]);
        @(negedge clk); check("R2 rdata held", host_rdata, std_m[8'h0B]);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        wr(2'd0, 8'h20); wr(2'd2, 8'h20); wr(2'd3, 8'hC3); ext_m[8'h20] = 8'hC3;
        rd(2'd3, v); check("R3 ext write/read 20h", v, 8'hC3);
        rd(2'd1, v); check("R3 std 20h untouched", v, std_m[8'h20]);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        wr(2'd0, 8'h40);
        rd(2'd1, v); check("R4 first read", v, std_m[8'h40]);
        wr(2'd1, 8'hE7); std_m[8'h40] = 8'hE7;
        rd(2'd1, v); check("R4 same index after write", v, 8'hE7);
        wr(2'd2, 8'h41); wr(2'd0, 8'h42);
        rd(2'd3, v); check("R4 ext index kept", v, ext_m[8'h41]);
    endtask

    task automatic t_msb();
        logic [7:0] v;
        wr(2'd0, 8'hC5); rd(2'd1, v); check("R5 std bit7 ignored", v, std_m[8'h45]);
        wr(2'd2, 8'hFF); rd(2'd3, v); check("R5 ext bit7 ignored", v, ext_m[8'h7F]);
    endtask

    task automatic t_alias();
        logic [7:0] v;
        wr(2'd2, 8'h20);
        ext_en = 1'b0;
        wr(2'd2, 8'h30); wr(2'd3, 8'h77); std_m[8'h30] = 8'h77;
        rd(2'd3, v); check("R6 alias read via offset 3", v, 8'h77);
        ext_en = 1'b1;
        rd(2'd1, v); check("R6 std index set via offset 2", v, 8'h77);
        rd(2'd3, v); check("R6 ext index untouched", v, ext_m[8'h20]);
        wr(2'd2, 8'h30); rd(2'd3, v); check("R6 ext bank untouched", v, ext_m[8'h30]);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        upd_busy = 1'b1;
        wr(2'd0, 8'h05); wr(2'd1, 8'h99);
        wr(2'd0, 8'h09); wr(2'd1, 8'h98);
        wr(2'd0, 8'h0A); wr(2'd1, 8'h12); std_m[8'h0A] = 8'h12;
        rd(2'd1, v); check("R8 ctrl 0Ah read/write in update", v, 8'h12);
        wr(2'd0, 8'h0E); wr(2'd1, 8'h34); std_m[8'h0E] = 8'h34;
        rd(2'd1, v); check("R8 user 0Eh in update", v, 8'h34);
        wr(2'd2, 8'h05); wr(2'd3, 8'hAB); ext_m[8'h05] = 8'hAB;
        rd(2'd3, v); check("R10 ext 05h written in update", v, 8'hAB);
        upd_busy = 1'b0;
        wr(2'd0, 8'h05); rd(2'd1, v); check("R7 05h write dropped", v, std_m[8'h05]);
        wr(2'd0, 8'h09); rd(2'd1, v); check("R7 09h write dropped", v, std_m[8'h09]);
    endtask

    task automatic t_tk();
        logic [7:0] v;
        wr(2'd0, 8'h03);
        @(negedge clk);
        host_addr = 2'd1; host_wdata = 8'hAA; host_wr = 1'b1;
        tk_we = 1'b1; tk_idx = 7'h03; tk_wdata = 8'h55;
        @(negedge clk);
        host_wr = 1'b0; tk_we = 1'b0; std_m[8'h03] = 8'h55;
        rd(2'd1, v); check("R9 time-keeping wins", v, 8'h55);
        upd_busy = 1'b1;
        @(negedge clk); tk_we = 1'b1; tk_idx = 7'h08; tk_wdata = 8'h19;
        @(negedge clk); tk_we = 1'b0; upd_busy = 1'b0;
        wr(2'd0, 8'h08); rd(2'd1, v); check("R9 time-keeping write in update", v, 8'h19);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fill_banks();
        t_reset();
        t_basic();
        t_ext();
        t_hold();
        t_msb();
        t_alias();
        t_busy();
        t_tk();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule